// File: doc/BRIEF.md
# Display Object List Header Parser

This block walks the list of display objects for one scanline and turns each object header into a descriptor: graphics address, palette, width in bytes, start position, write mode and indirect flag. A header is either four or five bytes long, depending on its second byte. After a header has been decoded, the block generates the addresses of the graphics bytes that belong to it. It can follow character codes through a base register for indirect objects, and it leaves out bytes that fall into the selected hole windows.

Each graphics byte that is fetched goes out on a valid/ready stream. The byte carries its target position in the line buffer, its palette and its write mode, so a pixel unpacker can place it. A pulse on `start` begins a walk, using the list pointer and control fields present in that cycle. `done` pulses when the end marker is found, and `cost` then holds the bus-cycle estimate for the whole list. Memory is read through a combinational port: `rd_data` must reflect `rd_addr` in the same cycle.

Top module: `objlist_parser`

## Requirements
- R1: A header whose second byte ANDed with 0x5F is zero ends the list. No data byte is emitted for it, `done` is high for one cycle, and the block returns idle. This holds even for second bytes 0x20, 0x80 and 0xA0.
- R2: A header whose second byte has a nonzero low 5 bits is 4 bytes long, in the order: address low, palette/width, address high, position. The palette is bits 7-5 of the palette/width byte and appears on `out_pal` bits 4-2, with bits 1-0 zero.
- R3: A header whose second byte has zero low 5 bits is 5 bytes long, in the order: address low, mode, address high, palette/width, position. Mode bit 7 is the write mode and mode bit 5 selects indirect fetching. In every header the width is 32 minus the low 5 bits of the palette/width byte.
- R4: In direct fetching the first data address is {high,low} plus `zone_ofs`×256 (modulo 65536), and it increments by one per byte for `width` bytes.
- R5: In indirect fetching, `width` code bytes are read from {high,low} onward. Each code is the low byte of a data address whose high byte is `char_base`+`zone_ofs` (modulo 256). With `wide_chr` set, two consecutive data bytes are fetched per code.
- R6: With `hole_mode` 2, a data address having both bits 15 and 12 set is not read or emitted. With `hole_mode` 1, the same applies to bits 15 and 11. Modes 0 and 3 suppress nothing. A suppressed byte still advances the address and the position.
- R7: `out_pos` starts at twice the header's position byte and advances by 4 per data byte when the write mode is 1, otherwise by 8, modulo 512.
- R8: The write mode is cleared when a walk starts and is kept across 4-byte headers. A 4-byte header always fetches directly.
- R9: With `read_mode` 1, headers are parsed but no data byte is read or emitted.
- R10: At `done`, `cost` equals the sum over headers of 10 (5-byte header) or 8 (4-byte header). Unless `read_mode` is 1, each header also adds width×3 for direct fetching, width×6 for indirect fetching, or width×9 for indirect fetching with `wide_chr`.
- R11: While `out_valid` is high and `out_ready` is low, `out_data`, `out_pos` and `rd_addr` hold, and no byte is lost or repeated.
- R12: After reset the block is idle with `out_valid`, `done` and `busy` low. A `start` pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a list walk (honoured only when idle) |
| list_ptr | input | 16 | Address of the first header |
| zone_ofs | input | 4 | Line offset within the current zone |
| hole_mode | input | 2 | Hole window select (1, 2 active) |
| char_base | input | 8 | High address base for indirect characters |
| wide_chr | input | 1 | Two data bytes per indirect character |
| read_mode | input | 2 | Pixel read mode; 1 suppresses data fetches |
| rd_en | output | 1 | Memory read strobe |
| rd_addr | output | 16 | Memory read address |
| rd_data | input | 8 | Memory read data, same cycle as address |
| out_valid | output | 1 | Data byte available |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Fetched graphics byte |
| out_pos | output | 9 | Line-buffer target position |
| out_pal | output | 5 | Palette number in bits 4-2 |
| out_wm | output | 1 | Write mode of the byte's object |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-list pulse |
| cost | output | 16 | Accumulated bus-cycle estimate |

## Verification
Lists of 4-byte headers are swept over every palette and several zone offsets. Their graphics cross a page boundary, which separates correct 16-bit address increment from page wrap. Extended headers are run with each mode pattern and followed by 4-byte headers, which shows whether the write mode is kept and the indirect flag is cleared. Indirect lists cover both character widths and two base values, and hole modes 0 to 3 run over address ranges that straddle both windows; these show which bytes are skipped yet still step the position. Empty lists with each terminating second byte, read mode 1, a position that wraps and a throttled ready (with a stray start) complete the set. Each list is checked against a byte-exact stream and a cost figure computed in the bench.

// File: rtl/olp_pkg.sv
package olp_pkg;
  localparam int ADDR_W = 16;
  localparam int POS_W  = 9;
  localparam int COST_W = 16;
  localparam int WID_W  = 6;
  localparam int HIDX_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_LIST,
    ST_DATA,
    ST_DONE
  } olp_state_e;
endpackage

// File: rtl/olp_hdr_decode.sv
module olp_hdr_decode #(
  parameter int WID_W = olp_pkg::WID_W
) (
  input  logic [7:0]       mode_b,
  input  logic [7:0]       pw_b,
  output logic             is_end,
  output logic             is_ext,
  output logic [2:0]       pal,
  output logic [WID_W-1:0] width
);
  always_comb begin
    is_end = (mode_b & 8'h5F) == 8'h00;
    is_ext = (mode_b[4:0] == 5'd0);
    pal    = pw_b[7:5];
    width  = WID_W'({1'b0, ~pw_b[4:0]}) + WID_W'(1);
  end
endmodule

// File: rtl/olp_hole_mask.sv
module olp_hole_mask #(
  parameter int ADDR_W = olp_pkg::ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        mode,
  output logic              skip
);
  localparam logic [ADDR_W-1:0] WIN_A = ADDR_W'(16'h9000);
  localparam logic [ADDR_W-1:0] WIN_B = ADDR_W'(16'h8800);

  always_comb begin
    case (mode)
      2'd2:    skip = (addr & WIN_A) == WIN_A;
      2'd1:    skip = (addr & WIN_B) == WIN_B;
      default: skip = 1'b0;
    endcase
  end
endmodule

// File: rtl/olp_cost.sv
module olp_cost #(
  parameter int COST_W = olp_pkg::COST_W,
  parameter int WID_W  = olp_pkg::WID_W
) (
  input  logic              is_ext,
  input  logic              ind,
  input  logic              wide,
  input  logic [1:0]        rmode,
  input  logic [WID_W-1:0]  width,
  output logic [COST_W-1:0] incr
);
  logic [3:0] mult;

  always_comb begin
    mult = ind ? (wide ? 4'd9 : 4'd6) : 4'd3;
    incr = is_ext ? COST_W'(10) : COST_W'(8);
    if (rmode != 2'd1)
      incr = incr + COST_W'(width) * COST_W'(mult);
  end
endmodule

// File: rtl/objlist_parser.sv
module objlist_parser #(
  parameter int ADDR_W = olp_pkg::ADDR_W,
  parameter int POS_W  = olp_pkg::POS_W,
  parameter int COST_W = olp_pkg::COST_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] list_ptr,
  input  logic [3:0]        zone_ofs,
  input  logic [1:0]        hole_mode,
  input  logic [7:0]        char_base,
  input  logic              wide_chr,
  input  logic [1:0]        read_mode,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic [POS_W-1:0]  out_pos,
  output logic [4:0]        out_pal,
  output logic              out_wm,
  output logic              busy,
  output logic              done,
  output logic [COST_W-1:0] cost
);
  import olp_pkg::*;

  localparam int WID_W  = olp_pkg::WID_W;
  localparam int HIDX_W = olp_pkg::HIDX_W;
  localparam logic [POS_W-1:0] STEP_WIDE = POS_W'(4);
  localparam logic [POS_W-1:0] STEP_NARR = POS_W'(8);

  olp_state_e state_q, state_d;
  logic [HIDX_W-1:0] hidx_q, hidx_d;
  logic ext_q, ext_d, wm_q, wm_d, ind_q, ind_d, sub_q, sub_d;
  logic [7:0] lo_q, lo_d, hi_q, hi_d;
  logic [2:0] pal_q, pal_d;
  logic [WID_W-1:0] wid_q, wid_d, rem_q, rem_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic [ADDR_W-1:0] dl_q, dl_d, laddr_q, laddr_d, daddr_q, daddr_d;
  logic [COST_W-1:0] cost_q, cost_d, cost_incr;
  logic [3:0] ofs_q, ofs_d;
  logic [1:0] hole_q, hole_d, rm_q, rm_d;
  logic [7:0] cb_q, cb_d;
  logic wide_q, wide_d;

  logic hd_end, hd_ext, skip, hdr_done, advance;
  logic [2:0] hd_pal;
  logic [WID_W-1:0] hd_width;

  olp_hdr_decode #(.WID_W(WID_W)) u_dec (
    .mode_b(rd_data), .pw_b(rd_data), .is_end(hd_end), .is_ext(hd_ext),
    .pal(hd_pal), .width(hd_width)
  );

  olp_hole_mask #(.ADDR_W(ADDR_W)) u_hole (
    .addr(daddr_q), .mode(hole_q), .skip(skip)
  );

  olp_cost #(.COST_W(COST_W), .WID_W(WID_W)) u_cost (
    .is_ext(ext_q), .ind(ind_q), .wide(wide_q), .rmode(rm_q),
    .width(wid_q), .incr(cost_incr)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;  hidx_d = hidx_q;  ext_d = ext_q;  wm_d = wm_q;
    ind_d = ind_q;      sub_d = sub_q;    lo_d = lo_q;    hi_d = hi_q;
    pal_d = pal_q;      wid_d = wid_q;    rem_d = rem_q;  pos_d = pos_q;
    dl_d = dl_q;        laddr_d = laddr_q; daddr_d = daddr_q;
    cost_d = cost_q;    ofs_d = ofs_q;    hole_d = hole_q; rm_d = rm_q;
    cb_d = cb_q;        wide_d = wide_q;
    rd_en = 1'b0;  rd_addr = dl_q;  out_valid = 1'b0;
    hdr_done = 1'b0;  advance = 1'b0;

    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_HDR;  hidx_d = '0;  dl_d = list_ptr;
          ofs_d = zone_ofs;  hole_d = hole_mode;  cb_d = char_base;
          wide_d = wide_chr; rm_d = read_mode;
          wm_d = 1'b0;  ind_d = 1'b0;  cost_d = '0;
        end
      end
      ST_HDR: begin
        rd_en = 1'b1;  rd_addr = dl_q;
        dl_d = dl_q + ADDR_W'(1);
        hidx_d = hidx_q + HIDX_W'(1);
        case (hidx_q)
          3'd0: lo_d = rd_data;
          3'd1: begin
            if (hd_end) begin
              state_d = ST_DONE;  dl_d = dl_q;
            end else if (hd_ext) begin
              ext_d = 1'b1;  wm_d = rd_data[7];  ind_d = rd_data[5];
            end else begin
              ext_d = 1'b0;  ind_d = 1'b0;  pal_d = hd_pal;  wid_d = hd_width;
            end
          end
          3'd2: hi_d = rd_data;
          3'd3: begin
            if (ext_q) begin
              pal_d = hd_pal;  wid_d = hd_width;
            end else begin
              hdr_done = 1'b1;
            end
          end
          default: hdr_done = 1'b1;
        endcase
        if (hdr_done) begin
          hidx_d  = '0;
          cost_d  = cost_q + cost_incr;
          pos_d   = {rd_data, 1'b0};
          rem_d   = wid_q;
          sub_d   = 1'b0;
          laddr_d = {hi_q, lo_q};
          daddr_d = {hi_q + {4'b0, ofs_q}, lo_q};
          if (rm_q == 2'd1)  state_d = ST_HDR;
          else if (ind_q)    state_d = ST_LIST;
          else               state_d = ST_DATA;
        end
      end
      ST_LIST: begin
        rd_en = 1'b1;  rd_addr = laddr_q;
        laddr_d = laddr_q + ADDR_W'(1);
        daddr_d = {cb_q + {4'b0, ofs_q}, rd_data};
        sub_d = 1'b0;
        state_d = ST_DATA;
      end
      ST_DATA: begin
        rd_addr = daddr_q;
        if (skip) begin
          advance = 1'b1;
        end else begin
          rd_en = 1'b1;  out_valid = 1'b1;
          advance = out_ready;
        end
        if (advance) begin
          daddr_d = daddr_q + ADDR_W'(1);
          pos_d = pos_q + (wm_q ? STEP_WIDE : STEP_NARR);
          if (ind_q && wide_q && !sub_q) begin
            sub_d = 1'b1;
          end else begin
            sub_d = 1'b0;
            rem_d = rem_q - WID_W'(1);
            if (rem_q == WID_W'(1)) state_d = ST_HDR;
            else if (ind_q)         state_d = ST_LIST;
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;  hidx_q <= '0;  ext_q <= 1'b0;  wm_q <= 1'b0;
      ind_q <= 1'b0;  sub_q <= 1'b0;  lo_q <= '0;  hi_q <= '0;
      pal_q <= '0;  wid_q <= '0;  rem_q <= '0;  pos_q <= '0;
      dl_q <= '0;  laddr_q <= '0;  daddr_q <= '0;  cost_q <= '0;
      ofs_q <= '0;  hole_q <= '0;  rm_q <= '0;  cb_q <= '0;  wide_q <= 1'b0;
    end else begin
      state_q <= state_d;  hidx_q <= hidx_d;  ext_q <= ext_d;  wm_q <= wm_d;
      ind_q <= ind_d;  sub_q <= sub_d;  lo_q <= lo_d;  hi_q <= hi_d;
      pal_q <= pal_d;  wid_q <= wid_d;  rem_q <= rem_d;  pos_q <= pos_d;
      dl_q <= dl_d;  laddr_q <= laddr_d;  daddr_q <= daddr_d;  cost_q <= cost_d;
      ofs_q <= ofs_d;  hole_q <= hole_d;  rm_q <= rm_d;  cb_q <= cb_d;
      wide_q <= wide_d;
    end
  end

  assign out_data = rd_data;
  assign out_pos  = pos_q;
  assign out_pal  = {pal_q, 2'b00};
  assign out_wm   = wm_q;
  assign busy     = (state_q == ST_HDR) || (state_q == ST_LIST) || (state_q == ST_DATA);
  assign done     = (state_q == ST_DONE);
  assign cost     = cost_q;
endmodule

// File: rtl/objlist_parser_chk.sv
module objlist_parser_chk #(
  parameter int ADDR_W = olp_pkg::ADDR_W,
  parameter int POS_W  = olp_pkg::POS_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_data,
  input logic [POS_W-1:0]  out_pos,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [1:0]        hole_q,
  input logic [1:0]        rm_q
);
  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R6
  hole_win_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && hole_q == 2'd2) |-> ((rd_addr & 16'h9000) != 16'h9000));

  // R6
  hole_win_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && hole_q == 2'd1) |-> ((rd_addr & 16'h8800) != 16'h8800));

  // R9
  rm1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rm_q == 2'd1) |-> !out_valid);

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_pos) && $stable(rd_addr)));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid);
endmodule

bind objlist_parser objlist_parser_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_pos(out_pos), .rd_addr(rd_addr), .hole_q(hole_q), .rm_q(rm_q)
);

// File: tb/objlist_parser_bench.sv
module objlist_parser_bench;
  localparam int CLK_PERIOD = 10;

  logic clk, rst_n, start, wide_chr, rd_en, out_valid, out_ready, out_wm, busy, done;
  logic [15:0] list_ptr, rd_addr, cost;
  logic [3:0]  zone_ofs;
  logic [1:0]  hole_mode, read_mode;
  logic [7:0]  char_base, rd_data, out_data;
  logic [8:0]  out_pos;
  logic [4:0]  out_pal;

  logic [7:0] lst [256];
  int wp;
  int n_checks, n_errors;
  bit stall;

  logic [7:0]  exp_d   [1024];
  logic [8:0]  exp_p   [1024];
  logic [4:0]  exp_pal [1024];
  logic        exp_wm  [1024];
  int exp_n, exp_cost;

  objlist_parser u_objlist_parser (
    .clk(clk), .rst_n(rst_n), .start(start), .list_ptr(list_ptr),
    .zone_ofs(zone_ofs), .hole_mode(hole_mode), .char_base(char_base),
    .wide_chr(wide_chr), .read_mode(read_mode), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_pos(out_pos),
    .out_pal(out_pal), .out_wm(out_wm), .busy(busy), .done(done), .cost(cost)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] bmem(input logic [15:0] a);
    if (a[15:8] == 8'h01) return lst[a[7:0]];
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  always_comb rd_data = bmem(rd_addr);

  task automatic check(input string rq, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic bit in_hole(input logic [15:0] a);
    return (hole_mode == 2'd2 && (a & 16'h9000) == 16'h9000) ||
           (hole_mode == 2'd1 && (a & 16'h8800) == 16'h8800);
  endfunction

  task automatic emit(inout logic [15:0] a, inout logic [8:0] pos, input logic [2:0] pal, input logic wm);
    if (!in_hole(a)) begin
      exp_d[exp_n] = bmem(a);  exp_p[exp_n] = pos;
      exp_pal[exp_n] = {pal, 2'b00};  exp_wm[exp_n] = wm;
      exp_n++;
    end
    a = a + 16'd1;
    pos = pos + (wm ? 9'd4 : 9'd8);
  endtask

  // reference walk computed from the requirements
  task automatic model();
    logic [15:0] dl, ga, a;
    logic [7:0] b1, lo, hi, pw, hp, ch;
    logic [8:0] pos;
    logic wm, ind;
    int w, mult;
    dl = list_ptr;  wm = 1'b0;  exp_n = 0;  exp_cost = 0;
    for (int g = 0; g < 64; g++) begin
      b1 = bmem(dl + 16'd1);
      if ((b1 & 8'h5F) == 8'h00) break;
      lo = bmem(dl);  hi = bmem(dl + 16'd2);
      if (b1[4:0] == 5'd0) begin
        pw = bmem(dl + 16'd3);  hp = bmem(dl + 16'd4);  dl = dl + 16'd5;
        wm = b1[7];  ind = b1[5];  exp_cost += 10;
      end else begin
        pw = b1;  hp = bmem(dl + 16'd3);  dl = dl + 16'd4;
        ind = 1'b0;  exp_cost += 8;
      end
      w = 32 - int'(pw[4:0]);
      mult = ind ? (wide_chr ? 9 : 6) : 3;
      if (read_mode == 2'd1) continue;
      exp_cost += w * mult;
      pos = {hp, 1'b0};
      ga = {hi, lo};
      if (!ind) begin
        a = ga + {4'b0, zone_ofs, 8'h00};
        for (int i = 0; i < w; i++) emit(a, pos, pw[7:5], wm);
      end else begin
        for (int i = 0; i < w; i++) begin
          ch = bmem(ga + 16'(i));
          a = {char_base + {4'b0, zone_ofs}, ch};
          for (int j = 0; j < (wide_chr ? 2 : 1); j++) emit(a, pos, pw[7:5], wm);
        end
      end
    end
  endtask

  task automatic new_list();
    for (int i = 0; i < 256; i++) lst[i] = 8'h00;
    wp = 0;
  endtask

  task automatic put4(input logic [7:0] lo, pw, hi, hp);
    lst[wp] = lo;  lst[wp+1] = pw;  lst[wp+2] = hi;  lst[wp+3] = hp;
    wp += 4;
  endtask

  task automatic put5(input logic [7:0] lo, md, hi, pw, hp);
    lst[wp] = lo;  lst[wp+1] = md;  lst[wp+2] = hi;  lst[wp+3] = pw;  lst[wp+4] = hp;
    wp += 5;
  endtask

  task automatic run_list(input string rq);
    int got, cyc;
    bit fin;
    got = 0;  cyc = 0;  fin = 1'b0;
    model();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!fin && cyc < 4000) begin
      out_ready = stall ? ((cyc % 3) != 1) : 1'b1;
      start = (stall && cyc == 5);   // R12: ignored while busy
      #1;
      if (out_valid && out_ready) begin
        if (got < exp_n)
          check(rq, {out_data, out_pos, out_pal, out_wm} ==
                    {exp_d[got], exp_p[got], exp_pal[got], exp_wm[got]},
                32'({out_data, out_pos, out_pal, out_wm}),
                32'({exp_d[got], exp_p[got], exp_pal[got], exp_wm[got]}));
        else
          check(rq, 1'b0, 32'(got), 32'(exp_n));
        got++;
      end
      if (done) begin
        fin = 1'b1;
        check(rq, got == exp_n, 32'(got), 32'(exp_n));
        check("R10", int'(cost) == exp_cost, 32'(cost), 32'(exp_cost));
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    if (!fin) check("watchdog", 1'b0, 32'(cyc), 32'(0));
  endtask

  task automatic hole_list();
    new_list();
    put5(8'hF0, 8'h40, 8'h87, 8'h00, 8'h10);
    put5(8'hF8, 8'h40, 8'h8F, 8'h20, 8'h30);
    put5(8'h00, 8'h60, 8'h30, 8'h1E, 8'h50);
  endtask

  initial begin
    n_checks = 0;  n_errors = 0;  stall = 1'b0;
    rst_n = 1'b0;  start = 1'b0;  out_ready = 1'b1;
    list_ptr = 16'h0100;  zone_ofs = 4'd0;  hole_mode = 2'd0;
    char_base = 8'h40;  wide_chr = 1'b0;  read_mode = 2'd0;
    new_list();
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12", busy == 1'b0, 32'(busy), 32'(0));
    check("R12", out_valid == 1'b0, 32'(out_valid), 32'(0));
    check("R12", done == 1'b0, 32'(done), 32'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check("R12", {busy, out_valid, rd_en} == 3'b000, 32'({busy, out_valid, rd_en}), 32'(0));

    // R1: empty lists with various terminating second bytes
    foreach (lst[i]) lst[i] = 8'h00;
    run_list("R1");
    new_list();  lst[1] = 8'hA0;  lst[0] = 8'h55;  run_list("R1");
    new_list();  lst[1] = 8'h20;  run_list("R1");
    new_list();  lst[1] = 8'h80;  run_list("R1");

    // R2 R4 R7: 4-byte headers swept over palettes and offsets
    for (int p = 0; p < 8; p++) begin
      for (int k = 0; k < 3; k++) begin
        zone_ofs = (k == 0) ? 4'd0 : ((k == 1) ? 4'd7 : 4'd15);
        new_list();
        put4(8'h10 + 8'(p), {3'(p), 5'd29}, 8'h20 + 8'(p), 8'(p * 9));
        put4(8'hFE, {3'(7 - p), 5'd28}, 8'h3F, 8'h40);
        put4(8'h00, {3'(p), 5'd31}, 8'h70, 8'hA0);
        run_list("R2");
      end
    end
    zone_ofs = 4'd0;

    // R3 R8: extended headers, write mode kept across 4-byte headers
    new_list();
    put5(8'h00, 8'hC0, 8'h50, 8'hA0, 8'h10);
    put4(8'h80, 8'h5F, 8'h51, 8'h90);
    put5(8'h40, 8'h40, 8'h52, 8'h7C, 8'h20);
    put4(8'h44, 8'h3D, 8'h53, 8'h60);
    run_list("R3");
    new_list();
    put4(8'h00, 8'h3C, 8'h54, 8'h08);
    run_list("R8");

    // R5: indirect characters, both widths, two bases, then a 4-byte header
    for (int wd = 0; wd < 2; wd++) begin
      for (int m = 0; m < 2; m++) begin
        for (int cbi = 0; cbi < 2; cbi++) begin
          wide_chr = wd[0];
          char_base = cbi[0] ? 8'hC3 : 8'h40;
          zone_ofs = cbi[0] ? 4'd2 : 4'd0;
          new_list();
          put5(8'h30, m[0] ? 8'hE0 : 8'h60, 8'h22, 8'h7C, 8'h08);
          put4(8'h10, 8'h3E, 8'h23, 8'h80);
          run_list("R5");
        end
      end
    end
    wide_chr = 1'b0;  char_base = 8'h40;  zone_ofs = 4'd0;

    // R6: hole windows
    for (int h = 0; h < 4; h++) begin
      hole_mode = 2'(h);
      char_base = 8'h98;
      hole_list();
      run_list("R6");
    end
    hole_mode = 2'd0;  char_base = 8'h40;

    // R9 R10: read mode 1 parses but fetches nothing; other modes fetch
    for (int r = 0; r < 4; r++) begin
      read_mode = 2'(r);
      hole_list();
      run_list("R9");
    end
    read_mode = 2'd0;

    // R7: position wrap
    new_list();
    put4(8'h00, 8'h1C, 8'h60, 8'hFE);
    put5(8'h00, 8'hC0, 8'h61, 8'h1D, 8'hFF);
    run_list("R7");

    // R11 R12: throttled ready and a stray start while busy
    stall = 1'b1;
    wide_chr = 1'b1;
    hole_mode = 2'd1;
    char_base = 8'h98;
    hole_list();
    run_list("R11");
    wide_chr = 1'b0;  hole_mode = 2'd0;  char_base = 8'h40;
    new_list();
    put5(8'h00, 8'h60, 8'h24, 8'h78, 8'h04);
    put4(8'hF8, 8'h30, 8'h25, 8'h40);
    run_list("R11");
    stall = 1'b0;
    @(negedge clk);
    check("R12", busy == 1'b0, 32'(busy), 32'(0));

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule